// File: doc/BRIEF.md
# Scan-configured two-cell logic fabric

This block is a very small programmable logic fabric. It has two logic cells and a routing switch between them. Each cell is a 3-input, 2-output lookup table with a flip-flop behind each output and a per-output choice between the stored and the direct table value. The switch has four candidate inputs and two outputs, and each output is a 4-to-1 multiplexer. The first cell's outputs and two primary inputs are the candidates. The switch outputs address the second cell.

Every configuration bit sits in one 40-bit serial chain. The chain covers both tables, the four output-register selects and the two routing selects. A host loads the chain by raising `prog_en` and presenting one bit per clock on `prog_sdi`, and it can read the chain back on `prog_sdo` by shifting it again. While `prog_en` is high the user flip-flops are held clear, so no half-loaded function is captured. Once `prog_en` falls, the fabric runs the loaded function on the same clock.

Top module: `scan_logic_fabric`

## Requirements
- R1: While `rst_n` is low, every chain bit and every user flip-flop is zero, so `usr_out` reads 0 and `prog_sdo` reads 0.
- R2: On each clock with `prog_en` high, the chain moves one place. The bit on `prog_sdi` enters at position 39, and `prog_sdo` always shows position 0. After 40 shifts, the k-th bit shifted in sits at position k. Shifting 40 more times presents the same bits on `prog_sdo` in the order they were loaded.
- R3: While `prog_en` is low, the chain holds its contents and `prog_sdi` has no effect.
- R4: Chain layout, by position:
  - 0-15: first-cell table. Word w is held at bits 2w (output 0) and 2w+1 (output 1).
  - 16 and 17: register selects for first-cell outputs 0 and 1.
  - 18-19: switch output 0 select. 20-21: switch output 1 select. In each 2-bit field the lower position is the LSB, so it is shifted in first.
  - 22-37: second-cell table, laid out like the first.
  - 38 and 39: register selects for second-cell outputs 0 and 1.
- R5: The first cell's table address is `usr_in[2:0]`. `usr_out[1:0]` are the first cell's outputs 0 and 1, and `usr_out[3:2]` are the second cell's outputs 0 and 1.
- R6: Switch candidate 0 is first-cell output 0, candidate 1 is first-cell output 1, candidate 2 is `usr_in[0]` and candidate 3 is `usr_in[1]`. The second cell's address is {`usr_in[2]`, switch output 1, switch output 0}.
- R7: A register select of 0 makes that output follow its table entry in the same cycle. A select of 1 makes it show the table entry captured at the previous clock edge, and it holds that value between edges.
- R8: While `prog_en` is high, all user flip-flops are cleared. Just after programming ends, and before the next edge, every registered output reads 0.
- R9: Shifting the stream 1101011000000000111101010011010000000011, leftmost character first, makes all four outputs registered. With `usr_in[2]`=0, input values 0, 1, 2 and 3 give `usr_out` 0xB, 0xE, 0x2 and 0x9 one clock later. With `usr_in[2]`=1 the outputs read 0.
- R10: A 2-to-4 decoder maps onto the fabric and gives a one-hot `usr_out` of `usr_in[1:0]` in the same cycle. The first cell produces outputs d0 and d1, the switch passes `usr_in[0]` and `usr_in[1]` to the second cell, and the second cell produces d2 and d3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the configuration chain and the user flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_en | input | 1 | Shift enable for the chain; also holds the user flip-flops clear |
| prog_sdi | input | 1 | Serial configuration data in |
| prog_sdo | output | 1 | Serial configuration data out, the chain's position 0 |
| usr_in | input | 3 | Primary inputs: first-cell address and extra switch candidates |
| usr_out | output | 4 | Primary outputs of both cells |

## Verification
A wrong table bit stays hidden until the address that selects it is applied. It then shows on `usr_out` in the same cycle for a direct output, or one clock later for a registered one. So the bench applies every address under several configurations. A misplaced or lost chain bit shows up as the wrong function. It also appears on `prog_sdo` within the 40 clocks of a readback, which the bench compares position by position. A user flip-flop that is not cleared while programming shows up in the first cycle after `prog_en` falls, before any new edge.

// File: rtl/slf_pkg.sv
package slf_pkg;
  // cell geometry
  localparam int LUT_IN    = 3;
  localparam int LUT_OUT   = 2;
  // switch geometry
  localparam int XBAR_IN   = 4;
  localparam int XBAR_OUT  = 2;
  localparam int RST_STAGES = 2;

  // derived sizes
  localparam int LUT_WORDS = 1 << LUT_IN;
  localparam int TBL_BITS  = LUT_WORDS * LUT_OUT;
  localparam int XSEL_W    = $clog2(XBAR_IN);
  localparam int XBAR_BITS = XBAR_OUT * XSEL_W;
  localparam int CELL_BITS = TBL_BITS + LUT_OUT;
  localparam int CHAIN_LEN = 2 * CELL_BITS + XBAR_BITS;

  // field offsets along the chain
  localparam int A_OFF  = 0;
  localparam int XB_OFF = CELL_BITS;
  localparam int B_OFF  = CELL_BITS + XBAR_BITS;
endpackage

// File: rtl/slf_rst_sync.sv
module slf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/slf_cfg_chain.sv
module slf_cfg_chain #(
  parameter int LEN = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           sdi,
  output logic           sdo,
  output logic [LEN-1:0] cfg
);
  logic [LEN-1:0] cfg_q;
  logic [LEN-1:0] cfg_d;

  // new bits enter at the top and walk toward position 0
  always_comb begin
    if (shift_en) cfg_d = {sdi, cfg_q[LEN-1:1]};
    else          cfg_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
  assign sdo = cfg_q[0];
endmodule

// File: rtl/slf_lut_cell.sv
module slf_lut_cell #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 2,
  localparam int WORDS = 1 << IN_W,
  localparam int TBL_W = WORDS * OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [TBL_W-1:0] tbl,
  input  logic [OUT_W-1:0] reg_sel,
  input  logic [IN_W-1:0]  addr,
  output logic [OUT_W-1:0] word,
  output logic [OUT_W-1:0] q,
  output logic [OUT_W-1:0] y
);
  logic [OUT_W-1:0] q_d;

  assign word = tbl[addr*OUT_W +: OUT_W];

  // flops are forced clear while the fabric is being programmed
  always_comb begin
    if (hold) q_d = '0;
    else      q_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  for (genvar g = 0; g < OUT_W; g++) begin : g_outsel
    assign y[g] = reg_sel[g] ? q[g] : word[g];
  end
endmodule

// File: rtl/slf_switch.sv
module slf_switch #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2,
  localparam int SEL_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]        m,
  input  logic [N_OUT*SEL_W-1:0] sel,
  output logic [N_OUT-1:0]       o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_mux
    assign o[g] = m[sel[g*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/scan_logic_fabric.sv
module scan_logic_fabric
  import slf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_en,
  input  logic                 prog_sdi,
  output logic                 prog_sdo,
  input  logic [LUT_IN-1:0]    usr_in,
  output logic [2*LUT_OUT-1:0] usr_out
);
  logic                 rst_n_i;
  logic [CHAIN_LEN-1:0] cfg_bits;
  logic [LUT_OUT-1:0]   a_word, a_q, a_y;
  logic [LUT_OUT-1:0]   b_word, b_q, b_y;
  logic [XBAR_IN-1:0]   sw_in;
  logic [XBAR_OUT-1:0]  sw_out;
  logic [LUT_IN-1:0]    b_addr;

  slf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_i)
  );

  slf_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk(clk), .rst_n(rst_n_i), .shift_en(prog_en),
    .sdi(prog_sdi), .sdo(prog_sdo), .cfg(cfg_bits)
  );

  slf_lut_cell #(.IN_W(LUT_IN), .OUT_W(LUT_OUT)) u_cell_a (
    .clk(clk), .rst_n(rst_n_i), .hold(prog_en),
    .tbl(cfg_bits[A_OFF +: TBL_BITS]),
    .reg_sel(cfg_bits[A_OFF+TBL_BITS +: LUT_OUT]),
    .addr(usr_in), .word(a_word), .q(a_q), .y(a_y)
  );

  // candidates: first-cell outputs below, spare primary inputs above
  assign sw_in = {usr_in[XBAR_IN-LUT_OUT-1:0], a_y};

  slf_switch #(.N_IN(XBAR_IN), .N_OUT(XBAR_OUT)) u_switch (
    .m(sw_in), .sel(cfg_bits[XB_OFF +: XBAR_BITS]), .o(sw_out)
  );

  assign b_addr = {usr_in[LUT_IN-1:XBAR_OUT], sw_out};

  slf_lut_cell #(.IN_W(LUT_IN), .OUT_W(LUT_OUT)) u_cell_b (
    .clk(clk), .rst_n(rst_n_i), .hold(prog_en),
    .tbl(cfg_bits[B_OFF +: TBL_BITS]),
    .reg_sel(cfg_bits[B_OFF+TBL_BITS +: LUT_OUT]),
    .addr(b_addr), .word(b_word), .q(b_q), .y(b_y)
  );

  assign usr_out = {b_y, a_y};
endmodule

// File: rtl/scan_logic_fabric_chk.sv
module scan_logic_fabric_chk #(
  parameter int LEN = 40,
  parameter int OW  = 2
) (
  input logic           clk,
  input logic           rst_n_i,
  input logic           prog_en,
  input logic           prog_sdi,
  input logic           prog_sdo,
  input logic [LEN-1:0] cfg,
  input logic [OW-1:0]  a_word,
  input logic [OW-1:0]  a_q,
  input logic [OW-1:0]  b_word,
  input logic [OW-1:0]  b_q
);
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !prog_en |=> $stable(cfg));

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    prog_en |=> cfg[LEN-1] == $past(prog_sdi));

  // R2
  shift_exit_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    prog_en |=> prog_sdo == $past(cfg[1]));

  // R8
  prog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    prog_en |=> (a_q == '0 && b_q == '0));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !prog_en |=> (a_q == $past(a_word) && b_q == $past(b_word)));
endmodule

bind scan_logic_fabric scan_logic_fabric_chk #(.LEN(slf_pkg::CHAIN_LEN), .OW(slf_pkg::LUT_OUT)) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .prog_en(prog_en), .prog_sdi(prog_sdi),
  .prog_sdo(prog_sdo), .cfg(cfg_bits), .a_word(a_word), .a_q(a_q),
  .b_word(b_word), .b_q(b_q)
);

// File: tb/scan_logic_fabric_tb.sv
module scan_logic_fabric_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 40;
  localparam logic [LEN-1:0] STREAM = 40'b1101011000000000111101010011010000000011;
  // {usr_in, expected usr_out} for the stream configuration (R9)
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 4'hB}, {3'd1, 4'hE}, {3'd2, 4'h2}, {3'd3, 4'h9},
    {3'd4, 4'h0}, {3'd5, 4'h0}, {3'd6, 4'h0}, {3'd7, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n, prog_en, prog_sdi, prog_sdo;
  logic [2:0] usr_in;
  logic [3:0] usr_out;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_logic_fabric u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_sdi(prog_sdi),
    .prog_sdo(prog_sdo), .usr_in(usr_in), .usr_out(usr_out)
  );

  task automatic check(input string req, input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit k of cfg is shifted k-th, so it ends at chain position k (R2)
  task automatic load_cfg(input logic [LEN-1:0] cfg);
    @(negedge clk);
    prog_en = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      prog_sdi = cfg[k];
      @(negedge clk);
    end
    prog_en = 1'b0;
  endtask

  // shift the chain once round, recirculating, and compare what came out
  task automatic readback(input string req, input logic [LEN-1:0] exp);
    logic [LEN-1:0] got;
    @(negedge clk);
    prog_en = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      got[k] = prog_sdo;
      prog_sdi = got[k];
      @(negedge clk);
    end
    prog_en = 1'b0;
    check(req, got, exp);
  endtask

  function automatic logic [LEN-1:0] stream_to_cfg(input logic [LEN-1:0] s);
    logic [LEN-1:0] c;
    for (int k = 0; k < LEN; k++) c[k] = s[LEN-1-k];
    return c;
  endfunction

  // R10: decoder mapping, all selects direct
  function automatic logic [LEN-1:0] cfg_decoder();
    logic [LEN-1:0] c = '0;
    c[0] = 1'b1;            // first cell word0 out0 = d0
    c[3] = 1'b1;            // first cell word1 out1 = d1
    c[19:18] = 2'd2;        // switch out0 <- usr_in[0]
    c[21:20] = 2'd3;        // switch out1 <- usr_in[1]
    c[22 + 4] = 1'b1;       // second cell word2 out0 = d2
    c[22 + 7] = 1'b1;       // second cell word3 out1 = d3
    return c;
  endfunction

  // first cell passes its address through, registered; second cell direct
  function automatic logic [LEN-1:0] cfg_feedback();
    logic [LEN-1:0] c = '0;
    for (int w = 0; w < 8; w++) begin
      c[2*w]        = w[0];
      c[2*w+1]      = w[1];
      c[22 + 2*w]   = ~w[0];
      c[22 + 2*w+1] = w[1];
    end
    c[17:16] = 2'b11;
    c[19:18] = 2'd0;
    c[21:20] = 2'd1;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_en = 1'b0; prog_sdi = 1'b0; usr_in = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 usr_out in reset", LEN'(usr_out), LEN'(0));
    check("R1 prog_sdo in reset", LEN'(prog_sdo), LEN'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 / R4 stream configuration, walked by the vector table
    load_cfg(stream_to_cfg(STREAM));
    for (int i = 0; i < 8; i++) begin
      usr_in = VEC[i][6:4];
      @(negedge clk);
      check($sformatf("R9 R5 stream in=%0d", VEC[i][6:4]), LEN'(usr_out), LEN'(VEC[i][3:0]));
    end
    // R2 readback returns the stream in load order
    readback("R2 readback of stream", stream_to_cfg(STREAM));

    // R10 decoder, direct outputs
    load_cfg(cfg_decoder());
    for (int i = 0; i < 4; i++) begin
      usr_in = 3'(i);
      #1;
      check($sformatf("R10 R6 decoder in=%0d", i), LEN'(usr_out), LEN'(4'b0001 << i));
    end

    // R6 R7 feedback through the switch, registered first cell
    load_cfg(cfg_feedback());
    usr_in = 3'd1;
    @(negedge clk);
    check("R7 R6 registered in=1", LEN'(usr_out), LEN'(4'b0001));
    usr_in = 3'd2;
    #1;
    check("R7 output held between edges", LEN'(usr_out), LEN'(4'b0001));
    @(negedge clk);
    check("R7 R6 registered in=2", LEN'(usr_out), LEN'(4'b1110));
    usr_in = 3'd3;
    @(negedge clk);
    check("R7 registered in=3", LEN'(usr_out), LEN'(4'b1011));

    // R8 flops cleared while programming
    readback("R2 readback of feedback cfg", cfg_feedback());
    #1;
    check("R8 flops clear after programming", LEN'(usr_out), LEN'(4'b0100));
    @(negedge clk);
    check("R8 capture resumes", LEN'(usr_out), LEN'(4'b1011));

    // R3 serial input ignored without enable
    for (int k = 0; k < 12; k++) begin
      prog_sdi = k[0];
      @(negedge clk);
    end
    check("R3 outputs unchanged", LEN'(usr_out), LEN'(4'b1011));
    readback("R3 chain unchanged", cfg_feedback());

    // R1 asynchronous reset clears the loaded fabric
    rst_n = 1'b0;
    #1;
    check("R1 usr_out after reset", LEN'(usr_out), LEN'(0));
    check("R1 prog_sdo after reset", LEN'(prog_sdo), LEN'(0));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule